// File: doc/BRIEF.md
# Parity-Guarded Memory Access Controller

This block sits on the path between a processor's master port and a plain word-addressed memory. It adds single-bit error detection to one configurable address zone without widening the memory. The parity bits of protected words are kept as ordinary 32-bit words in a separate check region of the same memory. The controller reaches them with extra sequential memory accesses. It keeps one check word locally, so that neighbouring accesses do not fetch the same check word again.

An access outside the zone passes through a multiplexer with no added cycle. For an access inside the zone, the controller takes ownership of the memory port and holds the master off until every supplementary access is done.

- On a protected read it fetches the data word and, only if needed, the check word. It then compares parity and either returns the data or raises an error.
- On a protected write it stores the data first. It then writes back the check word with the one affected bit updated.

Top module: `ckmem_ctrl`

## Requirements
- R1: An access whose address lies outside the protected zone is presented to the memory in the same cycle with the same address, write enable and write data. `m_ready` equals `mem_gnt`, `mem_rvalid` and `mem_rdata` are forwarded unchanged, and `m_err` stays 0.
- R2: An address is protected when `(addr & ZONE_MASK) == ZONE_MATCH`. Its check word is at `CHK_BASE | ((addr & ~ZONE_MASK) >> 5)`, and its parity bit sits at bit position `addr[4:0]` of that check word.
- R3: With the memory granting at once and returning read data one cycle after the grant, a protected read completes as follows. `m_ready` and `m_rvalid` are high together in the 5th cycle of the request when the check word is held locally, and in the 7th cycle otherwise. The miss costs exactly one extra memory read.
- R4: Parity is even. The stored bit equals the XOR of the 32 data bits. On a match the read returns the memory data with `m_err` = 0. On a mismatch `m_err` = 1 and `m_rdata` = 0.
- R5: A protected write first writes the data word to its address and then writes the check word with only its own bit set to the parity of the new data. If the check word is not held, it is fetched first. `m_ready` rises in the 4th cycle on a hit and in the 6th on a miss, after 2 or 3 memory accesses respectively.
- R6: One check word and its address are held locally. A miss replaces the held copy and a protected write updates it, so later hits use the local copy even if the memory copy changes.
- R7: While a protected access is in progress `m_ready` stays low and no other request is taken. The access ends in a single response cycle.
- R8: A bypass write whose address equals the held check-word address discards the local copy, so the next protected access to that group fetches again.
- R9: `m_err` is only ever high together with `m_rvalid`, and never for a bypassed access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | 1 | Master request valid, held until `m_ready` |
| m_ready | output | 1 | Request accepted / completed |
| m_we | input | 1 | 1 = write, 0 = read |
| m_addr | input | AW | Word address |
| m_wdata | input | DW | Write data |
| m_rvalid | output | 1 | Read data valid |
| m_rdata | output | DW | Read data |
| m_err | output | 1 | Parity mismatch on a protected read |
| mem_req | output | 1 | Memory request |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DW | Memory read data |

## Verification
Bypassed accesses must show the memory request in the very cycle the master raises `m_valid`. Their read data then arrives one cycle after the grant. Protected reads are due in cycle 5 (hit) or 7 (miss), and protected writes in cycle 4 or 6, counted from the request's first cycle. The bench counts cycles from its own drive point and compares that count and the number of memory accesses against values derived from its own model of the held check word. Outputs are sampled on the falling edge, half a cycle after the registers that produce them.

// File: rtl/ckmem_pkg.sv
package ckmem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA_ACC,
        ST_CW_FETCH,
        ST_CHECK,
        ST_CW_WRITE,
        ST_RESP
    } ckm_state_e;

endpackage

// File: rtl/ckmem_zone_map.sv
module ckmem_zone_map #(
    parameter int            AW         = 12,
    parameter int            DW         = 32,
    parameter logic [AW-1:0] ZONE_MASK  = 12'hC00,
    parameter logic [AW-1:0] ZONE_MATCH = 12'h400,
    parameter logic [AW-1:0] CHK_BASE   = 12'h800
) (
    input  logic [AW-1:0] addr,
    output logic          in_zone,
    output logic [AW-1:0] cw_addr
);
    localparam int LG = $clog2(DW);

    // R2: zone membership by masked compare, check word by shifted offset
    assign in_zone = (addr & ZONE_MASK) == ZONE_MATCH;
    assign cw_addr = CHK_BASE | ((addr & ~ZONE_MASK) >> LG);

endmodule

// File: rtl/ckmem_parity.sv
module ckmem_parity #(
    parameter int   W   = 32,
    parameter logic ODD = 1'b0
) (
    input  logic [W-1:0] d,
    output logic         p
);
    assign p = (^d) ^ ODD;
endmodule

// File: rtl/ckmem_ctrl.sv
module ckmem_ctrl
    import ckmem_pkg::*;
#(
    parameter int            AW         = 12,
    parameter int            DW         = 32,
    parameter logic [AW-1:0] ZONE_MASK  = 12'hC00,
    parameter logic [AW-1:0] ZONE_MATCH = 12'h400,
    parameter logic [AW-1:0] CHK_BASE   = 12'h800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m_valid,
    output logic          m_ready,
    input  logic          m_we,
    input  logic [AW-1:0] m_addr,
    input  logic [DW-1:0] m_wdata,
    output logic          m_rvalid,
    output logic [DW-1:0] m_rdata,
    output logic          m_err,
    output logic          mem_req,
    input  logic          mem_gnt,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);
    localparam int LG = $clog2(DW);

    typedef struct packed {
        ckm_state_e    st;
        logic [AW-1:0] addr;
        logic [AW-1:0] cwa;
        logic          we;
        logic [DW-1:0] wdata;
        logic [DW-1:0] data;
        logic          pend;
        logic          hit;
        logic          err;
        logic          lv;
        logic [AW-1:0] ltag;
        logic [DW-1:0] lword;
    } regs_t;

    regs_t q, d;

    logic          zin_m;
    logic [AW-1:0] cw_m;
    logic          par_w, par_r;
    logic [LG-1:0] bit_q;
    logic [DW-1:0] upd_w;

    ckmem_zone_map #(
        .AW(AW), .DW(DW), .ZONE_MASK(ZONE_MASK),
        .ZONE_MATCH(ZONE_MATCH), .CHK_BASE(CHK_BASE)
    ) zmap_i (
        .addr(m_addr), .in_zone(zin_m), .cw_addr(cw_m)
    );

    ckmem_parity #(.W(DW), .ODD(1'b0)) par_w_i (.d(q.wdata), .p(par_w));
    ckmem_parity #(.W(DW), .ODD(1'b0)) par_r_i (.d(q.data),  .p(par_r));

    assign bit_q = q.addr[LG-1:0];

    always_comb begin
        upd_w        = q.lword;
        upd_w[bit_q] = par_w;
    end

    always_comb begin
        d         = q;
        m_ready   = 1'b0;
        m_rvalid  = 1'b0;
        m_rdata   = '0;
        m_err     = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.addr;
        mem_wdata = q.wdata;
        unique case (q.st)
            ST_IDLE: begin
                // bypass responses are forwarded only while idle
                m_rvalid = mem_rvalid;
                m_rdata  = mem_rdata;
                if (m_valid && !zin_m) begin
                    mem_req   = 1'b1;
                    mem_we    = m_we;
                    mem_addr  = m_addr;
                    mem_wdata = m_wdata;
                    m_ready   = mem_gnt;
                    if (mem_gnt && m_we && q.lv && (m_addr == q.ltag))
                        d.lv = 1'b0;
                end else if (m_valid) begin
                    d.st    = ST_DATA_ACC;
                    d.addr  = m_addr;
                    d.cwa   = cw_m;
                    d.we    = m_we;
                    d.wdata = m_wdata;
                    d.pend  = 1'b0;
                    d.err   = 1'b0;
                    d.hit   = q.lv && (q.ltag == cw_m);
                end
            end
            ST_DATA_ACC: begin
                if (!q.pend) begin
                    mem_req = 1'b1;
                    mem_we  = q.we;
                    if (mem_gnt) begin
                        if (q.we) d.st = q.hit ? ST_CW_WRITE : ST_CW_FETCH;
                        else      d.pend = 1'b1;
                    end
                end else if (mem_rvalid) begin
                    d.data = mem_rdata;
                    d.pend = 1'b0;
                    d.st   = q.hit ? ST_CHECK : ST_CW_FETCH;
                end
            end
            ST_CW_FETCH: begin
                mem_addr = q.cwa;
                if (!q.pend) begin
                    mem_req = 1'b1;
                    if (mem_gnt) d.pend = 1'b1;
                end else if (mem_rvalid) begin
                    d.pend  = 1'b0;
                    d.lv    = 1'b1;
                    d.ltag  = q.cwa;
                    d.lword = mem_rdata;
                    d.st    = q.we ? ST_CW_WRITE : ST_CHECK;
                end
            end
            ST_CHECK: begin
                d.err = q.lword[bit_q] != par_r;
                d.st  = ST_RESP;
            end
            ST_CW_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.cwa;
                mem_wdata = upd_w;
                if (mem_gnt) begin
                    d.lword = upd_w;
                    d.st    = ST_RESP;
                end
            end
            ST_RESP: begin
                m_ready = 1'b1;
                if (!q.we) begin
                    m_rvalid = 1'b1;
                    m_err    = q.err;
                    m_rdata  = q.err ? '0 : q.data;
                end
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    p_err_with_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        m_err |-> m_rvalid);
    p_err_zero_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_err |-> (m_rdata == '0));
    p_no_err_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !m_err);
    p_hold_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && q.st != ST_RESP) |-> !m_ready);
    p_resp_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RESP) |=> (q.st == ST_IDLE));
    p_hit_no_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DATA_ACC && q.hit) |=> (q.st != ST_CW_FETCH));
    p_cw_write_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.st == ST_CW_WRITE) |-> ($past(q.st) == ST_DATA_ACC || $past(q.st) == ST_CW_FETCH));

endmodule

// File: tb/ckmem_ctrl_tb_top.sv
`timescale 1ns/1ps
module ckmem_ctrl_tb_top;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam logic [AW-1:0] ZM  = 12'hC00;
    localparam logic [AW-1:0] ZMT = 12'h400;
    localparam logic [AW-1:0] CHK = 12'h800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_valid = 1'b0, m_we = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wdata = '0;
    logic m_ready, m_rvalid, m_err;
    logic [DW-1:0] m_rdata;
    logic mem_req, mem_we, mem_gnt, mem_rvalid;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ckmem_ctrl #(.AW(AW), .DW(DW), .ZONE_MASK(ZM), .ZONE_MATCH(ZMT), .CHK_BASE(CHK)) dut_i (
        .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready), .m_we(m_we),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_rvalid(m_rvalid), .m_rdata(m_rdata),
        .m_err(m_err), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    // behavioural memory: immediate grant, read data one cycle after grant
    logic [DW-1:0] mem [4096];
    logic rv_r = 1'b0;
    logic [DW-1:0] rd_r = '0;
    assign mem_gnt    = 1'b1;
    assign mem_rvalid = rv_r;
    assign mem_rdata  = rd_r;
    always @(posedge clk) begin
        rv_r <= 1'b0;
        if (mem_req && mem_gnt) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else begin rd_r <= mem[mem_addr]; rv_r <= 1'b1; end
        end
    end

    // bench model of the locally held check word
    logic mdl_lv = 1'b0;
    logic [AW-1:0] mdl_tag = '0;
    logic [DW-1:0] mdl_word = '0;

    function automatic logic zone_of(input logic [AW-1:0] a);
        return (a & ZM) == ZMT;
    endfunction
    function automatic logic [AW-1:0] cw_of(input logic [AW-1:0] a);
        return CHK | ((a & ~ZM) >> 5);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // one master transfer; counts cycles from the first request cycle
    task automatic xfer(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output logic e, output int cyc,
                        output int nacc, output logic freq, output logic [AW-1:0] faddr,
                        output logic [AW-1:0] lacc);
        bit got = 1'b0;
        bit fin = 1'b0;
        rd = '0; e = 1'b0; cyc = 0; nacc = 0; freq = 1'b0; faddr = '0; lacc = '0;
        @(posedge clk); #1;
        m_valid = 1'b1; m_we = we; m_addr = a; m_wdata = wd;
        while (!fin) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin freq = mem_req; faddr = mem_addr; end
            if (mem_req && mem_gnt) begin nacc++; lacc = mem_addr; end
            if (m_rvalid) begin got = 1'b1; rd = m_rdata; e = m_err; end
            if (m_ready) fin = 1'b1;
            else if (cyc > 40) begin
                chk(1'b0, "R7", "transfer hung", cyc, 0);
                fin = 1'b1;
            end
        end
        @(posedge clk); #1;
        m_valid = 1'b0; m_we = 1'b0;
        if (!we && !got) begin
            @(negedge clk);
            if (m_rvalid) begin rd = m_rdata; e = m_err; end
        end
    endtask

    task automatic p_write(input logic [AW-1:0] a, input logic [DW-1:0] wd);
        logic [DW-1:0] rd; logic e; int cyc, nacc; logic fr; logic [AW-1:0] fa, la;
        logic [AW-1:0] cw = cw_of(a);
        bit hit = mdl_lv && (mdl_tag == cw);
        logic [DW-1:0] w = hit ? mdl_word : mem[cw];
        xfer(1'b1, a, wd, rd, e, cyc, nacc, fr, fa, la);
        w[a[4:0]] = ^wd;
        mdl_lv = 1'b1; mdl_tag = cw; mdl_word = w;
        chk(cyc == (hit ? 4 : 6), "R5", "write latency", cyc, hit ? 4 : 6);
        chk(nacc == (hit ? 2 : 3), "R5", "write access count", nacc, hit ? 2 : 3);
        chk(mem[a] == wd, "R5", "data stored", mem[a], wd);
        chk(mem[cw] == w, "R5", "check word stored", mem[cw], w);
    endtask

    task automatic p_read(input logic [AW-1:0] a);
        logic [DW-1:0] rd; logic e; int cyc, nacc; logic fr; logic [AW-1:0] fa, la;
        logic [AW-1:0] cw = cw_of(a);
        bit hit = mdl_lv && (mdl_tag == cw);
        logic [DW-1:0] w = hit ? mdl_word : mem[cw];
        logic exp_e = (^mem[a]) != w[a[4:0]];
        logic [DW-1:0] exp_d = exp_e ? '0 : mem[a];
        xfer(1'b0, a, '0, rd, e, cyc, nacc, fr, fa, la);
        mdl_lv = 1'b1; mdl_tag = cw; mdl_word = w;
        chk(cyc == (hit ? 5 : 7), "R3", "read latency", cyc, hit ? 5 : 7);
        chk(nacc == (hit ? 1 : 2), "R3", "read access count", nacc, hit ? 1 : 2);
        if (!hit) chk(la == cw, "R2", "check word address", la, cw);
        chk(e == exp_e, "R4", "error flag", e, exp_e);
        chk(rd == exp_d, "R4", "read data", rd, exp_d);
    endtask

    task automatic b_write(input logic [AW-1:0] a, input logic [DW-1:0] wd);
        logic [DW-1:0] rd; logic e; int cyc, nacc; logic fr; logic [AW-1:0] fa, la;
        xfer(1'b1, a, wd, rd, e, cyc, nacc, fr, fa, la);
        if (mdl_lv && a == mdl_tag) mdl_lv = 1'b0;
        chk(cyc == 1 && fr && fa == a, "R1", "bypass write same cycle", cyc, 1);
        chk(mem[a] == wd, "R1", "bypass write data", mem[a], wd);
    endtask

    task automatic b_read(input logic [AW-1:0] a);
        logic [DW-1:0] rd; logic e; int cyc, nacc; logic fr; logic [AW-1:0] fa, la;
        logic [DW-1:0] exp_d = mem[a];
        xfer(1'b0, a, '0, rd, e, cyc, nacc, fr, fa, la);
        chk(cyc == 1 && nacc == 1 && fr && fa == a, "R1", "bypass read same cycle", cyc, 1);
        chk(rd == exp_d, "R1", "bypass read data", rd, exp_d);
        chk(e == 1'b0, "R9", "no error on bypass", e, 0);
    endtask

    initial begin : watchdog
        int n = 0;
        while (!done) begin
            @(posedge clk);
            n++;
            if (n > 150000) begin
                chk(1'b0, "R7", "watchdog expired", n, 0);
                finish_run();
            end
        end
    end

    initial begin : main
        logic [DW-1:0] good;
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!m_ready && !m_rvalid && !m_err && !mem_req, "R7", "reset outputs idle", m_ready, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // protected writes over two check-word groups (R5, R6)
        for (int i = 0; i < 64; i++)
            p_write(ZMT + 12'(i), (32'h1357_9BDF * 32'(i + 1)) ^ 32'(i));
        // protected reads of the same words, clean parity (R3, R4, R6)
        for (int i = 0; i < 64; i++) p_read(ZMT + 12'(i));

        // bypass region traffic (R1)
        for (int i = 0; i < 8; i++) b_write(12'h010 + 12'(i), 32'hA5A5_0000 | 32'(i));
        for (int i = 0; i < 8; i++) b_read(12'h010 + 12'(i));

        // zone membership sweep across the address space (R2)
        for (int i = 0; i < 64; i++) begin
            if (zone_of(12'(i * 64))) p_read(12'(i * 64));
            else                      b_read(12'(i * 64));
        end

        // single data bit flip in a protected word: miss path (R4)
        mem[12'h405] = mem[12'h405] ^ 32'h0000_0100;
        p_read(12'h405);
        p_read(12'h406);

        // check word bit flip, group not held: error on fetch (R4, R6)
        p_read(12'h400);
        mem[12'h801] = mem[12'h801] ^ (32'h1 << 10);
        p_read(12'h42A);
        p_read(12'h42B);
        // flip while held: local copy masks it (R6)
        mem[12'h801] = mem[12'h801] ^ (32'h1 << 11);
        p_read(12'h42B);

        // restore via bypass write to the held check word: must refetch (R8)
        good = '0;
        for (int j = 0; j < 32; j++) good[j] = ^mem[12'h420 + 12'(j)];
        b_write(12'h801, good);
        chk(mdl_lv == 1'b0, "R8", "model dropped held copy", mdl_lv, 0);
        p_read(12'h42B);
        p_read(12'h42A);

        // protected write repairs the flipped word (R5)
        p_write(12'h405, 32'hDEAD_BEEF);
        p_read(12'h405);

        // flip in unprotected region is not flagged (R9)
        mem[12'h012] = mem[12'h012] ^ 32'h8000_0000;
        b_read(12'h012);

        done = 1'b1;
        finish_run();
    end
endmodule